// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Core

This block is a small 32-bit processor core that fetches, decodes and fully executes one instruction in every clock cycle. It handles nine instructions: word load and store, the register-to-register operations add, subtract, AND, OR and signed set-less-than, a branch taken when two registers are equal, and an unconditional jump. The core keeps its instruction store and its data store apart. It also uses one adder for the sequential program counter and a second adder for the branch target. Because of this, no resource is needed twice within a cycle.

Both stores are loaded from outside through a shared backdoor port. This is done while the core is held in reset. For observation, the core drives its current program counter and the register-file write of the instruction now executing: whether a write happens, which register it targets and what value it writes.

Top module: `core_top`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and rf_we_o is 0. Reset is asynchronous and active low.
- R2: Each add, sub, and, or, slt, lw or sw instruction advances pc_o by 4 at the next rising edge. pc_o stays word aligned at all times.
- R3: An instruction with opcode bits[31:26]=0x00 is register-to-register. Its operation is picked by bits[5:0]: 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A slt. The operands are the registers named in bits[25:21] and bits[20:16]. The result goes to the register named in bits[15:11]. slt writes 1 when the first operand is smaller as a signed number, and 0 otherwise.
- R4: Opcode 0x23 (load) writes the data word at address reg[bits 25:21] + sign-extended bits[15:0] into the register named in bits[20:16].
- R5: Opcode 0x2B (store) writes reg[bits 20:16] to the data word at the same address that R4 computes. It never asserts rf_we_o.
- R6: Opcode 0x04 compares the two registers named in bits[25:21] and bits[20:16]. When they are equal, the next pc is pc+4 plus the sign-extended bits[15:0] shifted left by 2. When they differ, the next pc is pc+4. Backward offsets work as well.
- R7: Opcode 0x02 sets the next pc to {(pc+4)[31:28], bits[25:0], 2'b00}.
- R8: Register 0 always reads as zero. A write aimed at register 0 is dropped, and rf_we_o stays low for it.
- R9: Any other opcode writes nothing and advances pc by 4.
- R10: Both stores are indexed by byte-address bits [IDX_W+1:2]. Higher address bits are ignored, so an address outside the store's range wraps onto a lower word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_imem_we_i | input | 1 | Backdoor write strobe, instruction store |
| load_dmem_we_i | input | 1 | Backdoor write strobe, data store (wins over a core store) |
| load_addr_i | input | IDX_W | Backdoor word index |
| load_data_i | input | 32 | Backdoor write word |
| pc_o | output | 32 | Program counter of the instruction now executing |
| rf_we_o | output | 1 | Register write happens at the next edge |
| rf_waddr_o | output | 5 | Register being written |
| rf_wdata_o | output | 32 | Value being written |

## Verification
The bench uses the default IDX_W of 8, which gives two 256-word stores. At that size, a byte address of 0x404 lands on word 1 and an offset of -4 from register 0 lands on word 255. This lets one program exercise both the wrap-around and negative sign extension. The program also takes a forward branch, skips a not-taken branch, runs a jump whose target is carried in the field, and ends in a backward branch to itself. A behavioural model of the nine instructions follows every cycle of this program.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    AOP_ADD = 2'b00,
    AOP_SUB = 2'b01,
    AOP_FN  = 2'b10
  } alu_op_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_fn_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_src;
    logic    mem_to_reg;
    logic    reg_write;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/core_ctrl.sv
module core_ctrl
  import core_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o,
  output alu_fn_e    alu_fn_o
);
  always_comb begin
    ctrl_o = '{default: '0, alu_op: AOP_ADD};
    unique case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_op    = AOP_FN;
      end
      OP_LOAD: begin
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_write  = 1'b1;
      end
      OP_STORE: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = AOP_SUB;
      end
      OP_JUMP: ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    unique case (ctrl_o.alu_op)
      AOP_SUB: alu_fn_o = ALU_SUB;
      AOP_FN: begin
        unique case (funct_i)
          FN_SUB:  alu_fn_o = ALU_SUB;
          FN_AND:  alu_fn_o = ALU_AND;
          FN_OR:   alu_fn_o = ALU_OR;
          FN_SLT:  alu_fn_o = ALU_SLT;
          default: alu_fn_o = ALU_ADD;
        endcase
      end
      default: alu_fn_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  always_comb begin
    unique case (fn_i)
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SLT: res_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: res_o = a_i + b_i;
    endcase
  end
  assign zero_o = (res_o == '0);
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int W      = 32,
  parameter int NREG   = 32,
  localparam int AW    = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [W-1:0]  da_o,
  output logic [W-1:0]  db_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [NREG];

  // entry 0 never written, so it stays at its reset value of zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign da_o = (ra_i == '0) ? '0 : regs_q[ra_i];
  assign db_o = (rb_i == '0) ? '0 : regs_q[rb_i];
endmodule

// File: rtl/core_mem.sv
module core_mem #(
  parameter int W     = 32,
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [W-1:0]     rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/core_top.sv
module core_top
  import core_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_imem_we_i,
  input  logic             load_dmem_we_i,
  input  logic [IDX_W-1:0] load_addr_i,
  input  logic [31:0]      load_data_i,
  output logic [31:0]      pc_o,
  output logic             rf_we_o,
  output logic [4:0]       rf_waddr_o,
  output logic [31:0]      rf_wdata_o
);
  localparam int W = 32;

  logic [W-1:0] pc_q, pc_plus4, pc_next, br_target, j_target;
  logic [W-1:0] instr_w, imm_ext, rs_data, rt_data, alu_b, alu_res, dmem_rdata, wb_data;
  logic         alu_zero, core_dwe, dmem_we;
  logic [IDX_W-1:0] dmem_waddr;
  logic [W-1:0]     dmem_wdata;
  logic [4:0]   waddr;
  ctrl_t        ctrl;
  alu_fn_e      alu_fn;

  core_mem #(.W(W), .IDX_W(IDX_W)) u_imem (
    .clk_i, .we_i(load_imem_we_i), .waddr_i(load_addr_i), .wdata_i(load_data_i),
    .raddr_i(pc_q[IDX_W+1:2]), .rdata_o(instr_w)
  );

  core_ctrl u_ctrl (
    .opcode_i(instr_w[31:26]), .funct_i(instr_w[5:0]), .ctrl_o(ctrl), .alu_fn_o(alu_fn)
  );

  assign waddr = ctrl.reg_dst ? instr_w[15:11] : instr_w[20:16];

  core_regfile #(.W(W), .NREG(32)) u_rf (
    .clk_i, .rst_ni,
    .ra_i(instr_w[25:21]), .rb_i(instr_w[20:16]),
    .da_o(rs_data), .db_o(rt_data),
    .we_i(rf_we_o), .wa_i(waddr), .wd_i(wb_data)
  );

  assign imm_ext = {{16{instr_w[15]}}, instr_w[15:0]};
  assign alu_b   = ctrl.alu_src ? imm_ext : rt_data;

  core_alu #(.W(W)) u_alu (
    .a_i(rs_data), .b_i(alu_b), .fn_i(alu_fn), .res_o(alu_res), .zero_o(alu_zero)
  );

  // backdoor load wins over a core store
  assign core_dwe   = ctrl.mem_write & rst_ni;
  assign dmem_we    = load_dmem_we_i | core_dwe;
  assign dmem_waddr = load_dmem_we_i ? load_addr_i : alu_res[IDX_W+1:2];
  assign dmem_wdata = load_dmem_we_i ? load_data_i : rt_data;

  core_mem #(.W(W), .IDX_W(IDX_W)) u_dmem (
    .clk_i, .we_i(dmem_we), .waddr_i(dmem_waddr), .wdata_i(dmem_wdata),
    .raddr_i(alu_res[IDX_W+1:2]), .rdata_o(dmem_rdata)
  );

  assign wb_data = ctrl.mem_to_reg ? dmem_rdata : alu_res;

  // separate adders for sequential and branch targets
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[W-3:0], 2'b00};
  assign j_target  = {pc_plus4[31:28], instr_w[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                     pc_next = j_target;
    else if (ctrl.branch && alu_zero)  pc_next = br_target;
    else                               pc_next = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = ctrl.reg_write & rst_ni & (waddr != 5'd0);
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wb_data;
endmodule

// File: rtl/core_checks.sv
module core_checks
  import core_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_i,
  input logic [31:0] instr_i,
  input logic        rf_we_i,
  input logic [4:0]  rf_waddr_i
);
  logic seq_op;
  assign seq_op = instr_i[31:26] == OP_RTYPE || instr_i[31:26] == OP_LOAD ||
                  instr_i[31:26] == OP_STORE;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (pc_i == 32'd0 && !rf_we_i);
    end
  end

  assert_pc_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_i[1:0] == 2'b00);

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_op |=> pc_i == $past(pc_i) + 32'd4);

  assert_store_no_wb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[31:26] == OP_STORE |-> !rf_we_i);

  assert_jump_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[31:26] == OP_JUMP |=>
      pc_i == ((($past(pc_i) + 32'd4) & 32'hF000_0000) | {4'b0, $past(instr_i[25:0]), 2'b00}));

  assert_no_r0_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_i |-> rf_waddr_i != 5'd0);
endmodule

bind core_top core_checks u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pc_i(pc_o), .instr_i(instr_w),
  .rf_we_i(rf_we_o), .rf_waddr_i(rf_waddr_o)
);

// File: tb/sim_core_top.sv
module sim_core_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 8;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             load_imem_we_i = 1'b0, load_dmem_we_i = 1'b0;
  logic [IDX_W-1:0] load_addr_i = '0;
  logic [31:0]      load_data_i = '0;
  logic [31:0]      pc_o;
  logic             rf_we_o;
  logic [4:0]       rf_waddr_o;
  logic [31:0]      rf_wdata_o;

  core_top #(.IDX_W(IDX_W)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_imem [DEPTH];
  logic [31:0] m_dmem [DEPTH];
  logic [31:0] m_reg  [32];
  logic [31:0] m_pc;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int word_tgt);
    return {6'h02, word_tgt[25:0]};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load(bit to_imem, int idx, logic [31:0] data);
    @(negedge clk_i);
    load_imem_we_i = to_imem;
    load_dmem_we_i = !to_imem;
    load_addr_i    = idx[IDX_W-1:0];
    load_data_i    = data;
    if (to_imem) m_imem[idx] = data; else m_dmem[idx] = data;
    @(negedge clk_i);
    load_imem_we_i = 1'b0;
    load_dmem_we_i = 1'b0;
  endtask

  string pc_tag = "R1";

  // one model step: compare this cycle's outputs, then advance model state
  task automatic step();
    logic [31:0] ins, a, b, imm, addr, wd, npc;
    logic [5:0]  op;
    logic        we;
    logic [4:0]  wa;
    string       tag;
    check(pc_tag, "pc", pc_o, m_pc);
    ins = m_imem[m_pc[IDX_W+1:2]];
    op  = ins[31:26];
    a   = m_reg[ins[25:21]];
    b   = m_reg[ins[20:16]];
    imm = {{16{ins[15]}}, ins[15:0]};
    addr = a + imm;
    we = 0; wa = 0; wd = 0;
    npc = m_pc + 4;
    tag = "R9";
    case (op)
      6'h00: begin
        tag = "R3"; wa = ins[15:11]; we = 1;
        case (ins[5:0])
          6'h22: wd = a - b;
          6'h24: wd = a & b;
          6'h25: wd = a | b;
          6'h2A: wd = ($signed(a) < $signed(b)) ? 1 : 0;
          default: wd = a + b;
        endcase
      end
      6'h23: begin
        tag = (addr[31:IDX_W+2] != 0) ? "R10" : "R4";
        wa = ins[20:16]; we = 1; wd = m_dmem[addr[IDX_W+1:2]];
      end
      6'h2B: begin
        tag = (addr[31:IDX_W+2] != 0) ? "R10" : "R5";
        m_dmem[addr[IDX_W+1:2]] = b;
      end
      6'h04: begin
        tag = "R6";
        if (a == b) npc = m_pc + 4 + (imm << 2);
      end
      6'h02: begin
        tag = "R7";
        npc = {npc[31:28], ins[25:0], 2'b00};
      end
      default: ;
    endcase
    if (we && wa == 0) begin
      we = 0; tag = "R8";
    end
    check(tag, "rf_we", {31'd0, rf_we_o}, {31'd0, we});
    if (we) begin
      check(tag, "rf_waddr", {27'd0, rf_waddr_o}, {27'd0, wa});
      check(tag, "rf_wdata", rf_wdata_o, wd);
      m_reg[wa] = wd;
    end
    pc_tag = (op == 6'h04 || op == 6'h02) ? tag : "R2";
    m_pc = npc;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_reg[i] = 0;
    for (int i = 0; i < DEPTH; i++) m_imem[i] = 32'h0000_0020; // add r0,r0,r0
    m_pc = 0;
    for (int i = 0; i < DEPTH; i++) load(1'b1, i, m_imem[i]);
    load(1'b0, 0, 32'd5);
    load(1'b0, 1, 32'hFFFF_FFFD);
    load(1'b0, 255, 32'h0000_0077);
    // program
    load(1'b1, 0,  enc_i(6'h23, 0, 1, 0));        // lw r1,0
    load(1'b1, 1,  enc_i(6'h23, 0, 2, 4));        // lw r2,4
    load(1'b1, 2,  enc_r(1, 2, 3, 6'h20));        // add
    load(1'b1, 3,  enc_r(1, 2, 4, 6'h22));        // sub
    load(1'b1, 4,  enc_r(1, 2, 5, 6'h24));        // and
    load(1'b1, 5,  enc_r(1, 2, 6, 6'h25));        // or
    load(1'b1, 6,  enc_r(2, 1, 7, 6'h2A));        // slt -3<5 -> 1
    load(1'b1, 7,  enc_r(1, 2, 8, 6'h2A));        // slt 5<-3 -> 0
    load(1'b1, 8,  enc_r(1, 1, 0, 6'h20));        // write r0, dropped
    load(1'b1, 9,  enc_r(0, 1, 9, 6'h20));        // r9 = r0 + r1
    load(1'b1, 10, enc_i(6'h2B, 0, 4, 8));        // sw r4 -> word 2
    load(1'b1, 11, enc_i(6'h23, 0, 10, 8));       // lw back
    load(1'b1, 12, enc_i(6'h2B, 0, 3, 16'h0404)); // wraps to word 1
    load(1'b1, 13, enc_i(6'h23, 0, 11, 4));
    load(1'b1, 14, enc_i(6'h04, 1, 2, 5));        // beq not taken
    load(1'b1, 15, enc_i(6'h04, 1, 9, 2));        // beq taken -> 18
    load(1'b1, 16, enc_r(1, 1, 12, 6'h20));
    load(1'b1, 17, enc_r(1, 1, 12, 6'h20));
    load(1'b1, 18, enc_i(6'h23, 14, 13, -4));     // wraps to word 255
    load(1'b1, 19, 32'hFC21_0001);                // unknown opcode
    load(1'b1, 20, enc_j(24));
    for (int i = 21; i < 24; i++) load(1'b1, i, enc_r(1, 1, 15, 6'h20));
    load(1'b1, 24, enc_i(6'h04, 0, 0, -1));       // branch to self
    #1;
    // R1: held in reset
    check("R1", "reset pc", pc_o, 32'd0);
    check("R1", "reset rf_we", {31'd0, rf_we_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    for (int c = 0; c < 40; c++) begin
      step();
      @(negedge clk_i);
      #1;
    end
    // R8: r0 still reads zero through an add
    check("R8", "r9 from r0+r1", m_reg[9], 32'd5);
    check("R10", "wrapped store seen", m_reg[11], 32'd2);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule